// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Unit

This unit sits beside the core of a small 8-bit controller and collects interrupt events. Nine sources feed it: one external-pin event and eight timer events (two for timer 0, two for timer 2 and four for timer 1). Each arrives as a one-cycle pulse and sets a sticky flag. A flag turns into a request only when its per-source enable bit and the global enable input `gie` are both 1. When several requests are active, the one with the lowest vector address wins. The unit shows that vector together with `irq_valid`.

The core answers with a one-cycle `ack`, which clears the flag of the vector being shown. Software can also clear any flag by writing a one to its bit. A byte-wide register port with four addresses holds the timer enable register, the timer flag register, the external enable register and the external flag register. Reads are combinational.

The control path is a two-state machine.
- `ST_IDLE`: nothing is presented.
- Transition RAISE: `ST_IDLE` moves to `ST_PRESENT` when any request is active.
- `ST_PRESENT`: the latched winner drives `irq_vector`.
- Transition SERVE: `ack` returns the machine to `ST_IDLE` and clears the presented flag.
- Transition WITHDRAW: if every request disappears, the machine returns to `ST_IDLE`.
- Transition RETARGET: if no `ack` comes, the machine stays in `ST_PRESENT` and reloads the current winner each cycle.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset every register reads 0x00 at all four addresses and `irq_valid` is 0.
- R2: An event pulse sets its flag at the next clock edge, even when its enable bit or `gie` is 0. Flag positions:
  - The timer flag register (address 1) uses the same bit positions as the enable register.
  - The external flag is bit 5 of address 3.
- R3: `irq_valid` rises one clock after flag, enable bit and `gie` are all 1. For an enabled source, that is the second edge after its event pulse.
- R4: Each source has a fixed vector:
  - external 0x06
  - timer2 compare (bit 2) 0x08
  - timer2 overflow (bit 4) 0x0A
  - timer1 capture (bit 3) 0x0C
  - timer1 compare-A (bit 6) 0x0E
  - timer1 compare-B (bit 5) 0x10
  - timer1 overflow (bit 7) 0x12
  - timer0 compare (bit 0) 0x14
  - timer0 overflow (bit 1) 0x16
- R5: When several requests are active, the lowest vector is presented. While no `ack` comes, a newly arriving lower vector replaces the presented one one clock after its request appears.
- R6: `ack` while `irq_valid` is 1 clears only the presented flag and drops `irq_valid` for the next cycle. Other flags keep their values, and the next winner is presented one cycle later.
- R7: An event on the same edge as the `ack` that would clear its flag leaves that flag set.
- R8: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R9: In the external registers only bit 5 is stored. Bits 7..6 and 4..0 of addresses 2 and 3 always read 0.
- R10: The timer enable register (address 0) stores all eight bits as written.
- R11: Clearing `gie` or the enable bit drops `irq_valid` after the next edge, and the flag stays set.
- R12: `ack` while `irq_valid` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable from the core |
| ext_evt | input | 1 | External-pin event pulse |
| tmr_evt | input | 8 | Timer event pulses, in enable-register bit positions |
| ack | input | 1 | Vector accepted by the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 timer flags, 2 external enable, 3 external flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_valid | output | 1 | A vector is being presented |
| irq_vector | output | 8 | Presented vector address, 0 when idle |

## Verification
The main function is tried in three ways:
- Each of the nine sources is raised alone. This separates a wrong vector entry or a swapped bit position from a working path.
- Three timer events arrive together, and the external event arrives later. This tests whether the arbiter ranks by vector or by bit index, and whether a newer, lower vector displaces the one already shown.
- Events arrive with masking, with `gie` low, during `ack`, and when no vector is shown. These patterns separate the flag-latch path from the request path, and hardware clearing from software clearing.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int DATA_W  = 8;
    localparam int VEC_W   = 8;
    localparam int NUM_TMR = 8;
    localparam int NUM_SRC = NUM_TMR + 1;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int EXT_IDX = NUM_TMR;
    localparam int EXT_BIT = 5;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } irq_state_e;

    // Source index 0..7 is a timer bit position, index 8 is the external pin.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        logic [VEC_W-1:0] v;
        case (idx)
            0:       v = VEC_W'(8'h14);
            1:       v = VEC_W'(8'h16);
            2:       v = VEC_W'(8'h08);
            3:       v = VEC_W'(8'h0C);
            4:       v = VEC_W'(8'h0A);
            5:       v = VEC_W'(8'h10);
            6:       v = VEC_W'(8'h0E);
            7:       v = VEC_W'(8'h12);
            default: v = VEC_W'(8'h06);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag[i] <= 1'b0;
            else
                flag[i] <= set_pulse[i] | (flag[i] & ~sw_clr[i] & ~hw_clr[i]);
        end

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[i] |=> flag[i]);

        // R6
        hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_clr[i] && !set_pulse[i]) |=> !flag[i]);
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_unit_pkg::*;
#(
    parameter int              ADDR_W  = 2,
    parameter logic [ADDR_W-1:0] A_MASK  = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] A_TFLAG = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] A_XMASK = ADDR_W'(2),
    parameter logic [ADDR_W-1:0] A_XFLAG = ADDR_W'(3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] enables,
    output logic [NUM_SRC-1:0] w1c,
    output logic [DATA_W-1:0]  rdata
);

    logic [NUM_TMR-1:0] tmr_mask;
    logic               ext_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_mask <= '0;
            ext_en   <= 1'b0;
        end else if (we) begin
            if (addr == A_MASK)  tmr_mask <= wdata[NUM_TMR-1:0];
            if (addr == A_XMASK) ext_en   <= wdata[EXT_BIT];
        end
    end

    assign enables = {ext_en, tmr_mask};

    always_comb begin
        w1c = '0;
        if (we && addr == A_TFLAG) w1c[NUM_TMR-1:0] = wdata[NUM_TMR-1:0];
        if (we && addr == A_XFLAG) w1c[EXT_IDX]     = wdata[EXT_BIT];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MASK)       rdata[NUM_TMR-1:0] = tmr_mask;
        else if (addr == A_TFLAG) rdata[NUM_TMR-1:0] = flags[NUM_TMR-1:0];
        else if (addr == A_XMASK) rdata[EXT_BIT]     = ext_en;
        else if (addr == A_XFLAG) rdata[EXT_BIT]     = flags[EXT_IDX];
    end

    // R10
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MASK) |=> (tmr_mask == $past(wdata[NUM_TMR-1:0])));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_unit_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    output logic               any,
    output logic [SRC_W-1:0]   win_idx,
    output logic [VEC_W-1:0]   win_vec
);

    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_vec = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending[i] && (vec_of(i) < win_vec)) begin
                any     = 1'b1;
                win_idx = SRC_W'(i);
                win_vec = vec_of(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie,
    input  logic               ext_evt,
    input  logic [NUM_TMR-1:0] tmr_evt,
    input  logic               ack,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector
);

    irq_state_e         state, state_nx;
    logic [SRC_W-1:0]   cur_idx;
    logic [VEC_W-1:0]   cur_vec;
    logic [NUM_SRC-1:0] flags, enables, w1c, hw_clr, pending;
    logic               any;
    logic [SRC_W-1:0]   win_idx;
    logic [VEC_W-1:0]   win_vec;

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse ({ext_evt, tmr_evt}),
        .sw_clr    (w1c),
        .hw_clr    (hw_clr),
        .flag      (flags)
    );

    irq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .flags   (flags),
        .enables (enables),
        .w1c     (w1c),
        .rdata   (reg_rdata)
    );

    assign pending = flags & enables & {NUM_SRC{gie}};

    irq_arbiter u_arb (
        .pending (pending),
        .any     (any),
        .win_idx (win_idx),
        .win_vec (win_vec)
    );

    // Next state: RAISE, SERVE, WITHDRAW, RETARGET.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (any) state_nx = ST_PRESENT;
            ST_PRESENT: if (ack || !any) state_nx = ST_IDLE;
        endcase
    end

    // State register with the latched winner.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            cur_vec <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_PRESENT) begin
                cur_idx <= win_idx;
                cur_vec <= win_vec;
            end
        end
    end

    // Outputs.
    always_comb begin
        irq_valid  = 1'b0;
        irq_vector = '0;
        hw_clr     = '0;
        unique case (state)
            ST_IDLE: ;
            ST_PRESENT: begin
                irq_valid  = 1'b1;
                irq_vector = cur_vec;
                if (ack) hw_clr[cur_idx] = 1'b1;
            end
        endcase
    end

    // R3
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(gie));

    // R11
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_valid);

    // R6
    serve_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack) |=> !irq_valid);

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector >= VEC_W'(8'h06) && irq_vector <= VEC_W'(8'h16)
                       && !irq_vector[0]));

    // R12
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && ack && !reg_we && !ext_evt && tmr_evt == '0) |=> $stable(flags));

endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie = 1'b0;
    logic       ext_evt = 1'b0;
    logic [7:0] tmr_evt = '0;
    logic       ack = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_valid;
    logic [7:0] irq_vector;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    localparam logic [7:0] EXP_VEC [9] = '{8'h14, 8'h16, 8'h08, 8'h0C, 8'h0A,
                                           8'h10, 8'h0E, 8'h12, 8'h06};

    always #4 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .gie(gie), .ext_evt(ext_evt), .tmr_evt(tmr_evt),
        .ack(ack), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic x, input logic [7:0] t);
        ext_evt = x; tmr_evt = t;
        tick();
        ext_evt = 1'b0; tmr_evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reset read", d, 8'h00);
        end
        chk("R1 reset valid", {7'd0, irq_valid}, 8'h00);

        // Table walk: each source alone (R2 R3 R4 R6 R10)
        gie = 1'b1;
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h20);
        rd(2'd0, d);
        chk("R10 mask all ones", d, 8'hFF);
        for (int i = 0; i < 9; i++) begin
            if (i < 8) pulse(1'b0, 8'(1 << i));
            else       pulse(1'b1, 8'h00);
            chk("R3 not yet valid", {7'd0, irq_valid}, 8'h00);
            tick();
            chk("R3 valid after two edges", {7'd0, irq_valid}, 8'h01);
            chk("R4 vector", irq_vector, EXP_VEC[i]);
            ack = 1'b1;
            tick();
            ack = 1'b0;
            chk("R6 valid drops after ack", {7'd0, irq_valid}, 8'h00);
            rd(i < 8 ? 2'd1 : 2'd3, d);
            chk("R6 flag cleared by ack", d, 8'h00);
        end

        // R2: flag latches while disabled
        gie = 1'b0;
        wr(2'd0, 8'h00);
        pulse(1'b0, 8'h08);
        rd(2'd1, d);
        chk("R2 flag set while masked", d, 8'h08);
        wr(2'd0, 8'h08);
        chk("R3 no request with gie low", {7'd0, irq_valid}, 8'h00);
        gie = 1'b1;
        tick();
        chk("R3 request once gie set", {7'd0, irq_valid}, 8'h01);
        chk("R4 capture vector", irq_vector, 8'h0C);
        gie = 1'b0;
        tick();
        chk("R11 gie low withdraws", {7'd0, irq_valid}, 8'h00);
        rd(2'd1, d);
        chk("R11 flag kept", d, 8'h08);
        gie = 1'b1;
        tick();
        chk("R11 re-raised", {7'd0, irq_valid}, 8'h01);
        wr(2'd0, 8'h00);
        tick();
        chk("R11 mask clear withdraws", {7'd0, irq_valid}, 8'h00);

        // R8 write-one-to-clear
        wr(2'd1, 8'h00);
        rd(2'd1, d);
        chk("R8 zero write keeps flag", d, 8'h08);
        wr(2'd1, 8'h08);
        rd(2'd1, d);
        chk("R8 one write clears flag", d, 8'h00);

        // R5 priority among simultaneous and later requests
        wr(2'd0, 8'hFF);
        pulse(1'b0, 8'hA1);
        tick();
        chk("R5 lowest of three", irq_vector, 8'h10);
        pulse(1'b1, 8'h00);
        chk("R5 still old before request seen", irq_vector, 8'h10);
        tick();
        chk("R5 retarget to external", irq_vector, 8'h06);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        rd(2'd3, d);
        chk("R6 external cleared", d, 8'h00);
        rd(2'd1, d);
        chk("R6 others kept", d, 8'hA1);
        tick();
        chk("R6 next winner shown", irq_vector, 8'h10);

        // R7 event coincident with ack
        ack = 1'b1; tmr_evt = 8'h20;
        tick();
        ack = 1'b0; tmr_evt = 8'h00;
        rd(2'd1, d);
        chk("R7 flag stays set", d, 8'hA1);
        chk("R7 valid drops", {7'd0, irq_valid}, 8'h00);
        tick();
        chk("R7 re-presented", irq_vector, 8'h10);

        // R12 ack ignored when nothing presented
        wr(2'd0, 8'h00);
        tick();
        ack = 1'b1;
        tick();
        ack = 1'b0;
        rd(2'd1, d);
        chk("R12 idle ack changes no flag", d, 8'hA1);
        wr(2'd1, 8'hFF);

        // R9 reserved bits in external registers
        wr(2'd2, 8'hFF);
        rd(2'd2, d);
        chk("R9 external enable bits", d, 8'h20);
        gie = 1'b0;
        pulse(1'b1, 8'h00);
        rd(2'd3, d);
        chk("R9 external flag bits", d, 8'h20);
        wr(2'd3, 8'hDF);
        rd(2'd3, d);
        chk("R8 R9 zero at bit 5 keeps flag", d, 8'h20);
        wr(2'd3, 8'h20);
        rd(2'd3, d);
        chk("R8 external cleared", d, 8'h00);
        wr(2'd0, 8'h5A);
        rd(2'd0, d);
        chk("R10 mask pattern", d, 8'h5A);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule